// File: doc/BRIEF.md
# Reference and Time-Base Divider Chain

This block takes the crystal clock of a tuner synthesizer and derives three timing signals from it. The first is a one-cycle reference strobe for the phase detector, whose rate is picked from seven frequencies by a 3-bit select code. The second is a fixed controller clock near 400 kHz with equal high and low times. The third is a slow square-wave time base near 8 Hz, produced by a second counter that is clocked by the controller-clock divider.

The block also drives the three band outputs. Normally they copy three band bits. When the time-base enable is set, band output 0 carries the time base and the other two outputs keep following their bits.

The reference divider is a down-counter that loads its ratio only when it reaches terminal count. A new select code therefore never cuts a reference period short.

Top module: `refchain_top`

## Requirements
- R1: The reference strobe repeats every XTAL_HZ / f crystal cycles, where f is chosen by `ref_sel_i`: 0 = 100 kHz, 1 = 50 kHz, 2 = 25 kHz, 3 = 5 kHz, 4 = 10 kHz, 5 = 9 kHz, 6 = 1 kHz, 7 = 5 kHz. At 7.2 MHz the periods are 72, 144, 288, 1440, 720, 800, 7200 and 1440 cycles.
- R2: `ref_stb_o` is high for exactly one crystal cycle per reference period.
- R3: A change of `ref_sel_i` takes effect only after the current period has run out. The period in progress keeps its old length.
- R4: `ctl_clk_o` has a period of XTAL_HZ / CTRL_HZ cycles (18 by default), with high and low phases of equal length.
- R5: `tb_clk_o` is a square wave that toggles every XTAL_HZ / (2 * TB_HZ) crystal cycles. Each toggle falls on a wrap of the controller-clock divider.
- R6: With `tb_en_i` = 0, `band_o[i]` equals `band_i[i]` for i = 0..2, one crystal cycle after the input.
- R7: With `tb_en_i` = 1, `band_o[0]` equals the value `tb_clk_o` had one cycle earlier, and `band_o[2:1]` follow `band_i[2:1]` as in R6.
- R8: While reset is held, every output is 0. Reset is applied asynchronously and released on the second rising crystal edge after `rst_ni` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_sel_i | input | 3 | Reference frequency select code |
| band_i | input | 3 | Band bits |
| tb_en_i | input | 1 | Time-base enable; when set, routes the time base to band output 0 |
| ref_stb_o | output | 1 | One-cycle phase-detector reference strobe |
| ctl_clk_o | output | 1 | Controller clock |
| tb_clk_o | output | 1 | Time-base square wave |
| band_o | output | 3 | Band outputs (1 = output active) |

## Verification
The bench keeps the default 7.2 MHz crystal rate and the 400 kHz controller rate, so every reference ratio is measured at its true length: 72 cycles for the fastest code and 7200 for the slowest. It lowers TB_HZ to 4000 Hz, which makes a time-base half period 900 cycles instead of 450000. Toggles of the time base and its path onto band output 0 can then be seen many times within the run. The divider structure stays the same at this setting: a divide by 18, followed by a divide of the wrap ticks.

// File: rtl/refchain_pkg.sv
package refchain_pkg;

  localparam int unsigned NUM_CODES = 8;

  // Reference frequency in Hz for each select code.
  function automatic int unsigned ref_hz(input int unsigned code);
    case (code)
      0:       ref_hz = 100_000;
      1:       ref_hz = 50_000;
      2:       ref_hz = 25_000;
      3:       ref_hz = 5_000;
      4:       ref_hz = 10_000;
      5:       ref_hz = 9_000;
      6:       ref_hz = 1_000;
      default: ref_hz = 5_000;
    endcase
  endfunction

endpackage

// File: rtl/refchain_rst_sync.sv
module refchain_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_no = s2_q;
endmodule

// File: rtl/refchain_ref_div.sv
module refchain_ref_div
  import refchain_pkg::*;
#(
  parameter int unsigned XTAL_HZ = 7_200_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       stb_o
);
  localparam int unsigned MAX_RATIO = XTAL_HZ / 1_000;
  localparam int unsigned W         = $clog2(MAX_RATIO + 1);

  logic [W-1:0] reload_tab [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
    assign reload_tab[g] = W'(XTAL_HZ / ref_hz(g) - 1);
  end

  logic [W-1:0] cnt_q, cnt_d;
  logic         stb_q, stb_d;
  logic         at_end;

  assign at_end = (cnt_q == '0);

  always_comb begin
    stb_d = at_end;
    if (at_end) cnt_d = reload_tab[sel_i];
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign stb_o = stb_q;

  // R3: no reload while a period is in progress
  a_r3_no_midload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R2: strobe never lasts two cycles
  a_r2_single_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
endmodule

// File: rtl/refchain_ctl_div.sv
module refchain_ctl_div #(
  parameter int unsigned DIV = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o,
  output logic tick_o
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned W    = $clog2(DIV);

  logic [W-1:0] c_q, c_d;
  logic         clk_q, clk_d;
  logic         wrap, mid;

  assign wrap = (c_q == W'(DIV - 1));
  assign mid  = (c_q == W'(HALF - 1));

  always_comb begin
    c_d   = wrap ? '0 : c_q + W'(1);
    clk_d = (wrap || mid) ? ~clk_q : clk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q   <= '0;
      clk_q <= 1'b0;
    end else begin
      c_q   <= c_d;
      clk_q <= clk_d;
    end
  end

  assign clk_o  = clk_q;
  assign tick_o = wrap;

  // R4: counter advances by one until wrap
  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q != W'(DIV - 1)) |=> (c_q == $past(c_q) + W'(1)));

  // R4: clock output goes low again at every wrap
  a_r4_low_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> !clk_q);
endmodule

// File: rtl/refchain_tb_div.sv
module refchain_tb_div #(
  parameter int unsigned HALF = 25_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic tb_o
);
  localparam int unsigned W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [W-1:0] t_q, t_d;
  logic         tb_q, tb_d;
  logic         last;

  assign last = (t_q == W'(HALF - 1));

  always_comb begin
    t_d  = t_q;
    tb_d = tb_q;
    if (tick_i) begin
      if (last) begin
        t_d  = '0;
        tb_d = ~tb_q;
      end else begin
        t_d = t_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q  <= '0;
      tb_q <= 1'b0;
    end else begin
      t_q  <= t_d;
      tb_q <= tb_d;
    end
  end

  assign tb_o = tb_q;

  // R5: time base moves only on a prescaler wrap
  a_r5_toggle_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tb_q));
endmodule

// File: rtl/refchain_band_mux.sv
module refchain_band_mux (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] band_i,
  input  logic       tb_en_i,
  input  logic       tb_i,
  output logic [2:0] band_o
);
  logic [2:0] band_q, band_d;

  always_comb begin
    band_d = band_i;
    if (tb_en_i) band_d[0] = tb_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) band_q <= '0;
    else         band_q <= band_d;
  end

  assign band_o = band_q;

  // R6: upper outputs always copy band bits a cycle later
  a_r6_upper_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (band_q[2:1] == $past(band_i[2:1])));

  // R7: enabled time base lands on output 0
  a_r7_tb_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_en_i |=> (band_q[0] == $past(tb_i)));
endmodule

// File: rtl/refchain_top.sv
module refchain_top #(
  parameter int unsigned XTAL_HZ = 7_200_000,
  parameter int unsigned CTRL_HZ = 400_000,
  parameter int unsigned TB_HZ   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] ref_sel_i,
  input  logic [2:0] band_i,
  input  logic       tb_en_i,
  output logic       ref_stb_o,
  output logic       ctl_clk_o,
  output logic       tb_clk_o,
  output logic [2:0] band_o
);
  localparam int unsigned CTRL_DIV = XTAL_HZ / CTRL_HZ;
  localparam int unsigned TB_HALF  = CTRL_HZ / (2 * TB_HZ);

  logic rst_n;
  logic ctl_tick;

  refchain_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  refchain_ref_div #(.XTAL_HZ(XTAL_HZ)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .sel_i  (ref_sel_i),
    .stb_o  (ref_stb_o)
  );

  refchain_ctl_div #(.DIV(CTRL_DIV)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clk_o  (ctl_clk_o),
    .tick_o (ctl_tick)
  );

  refchain_tb_div #(.HALF(TB_HALF)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (ctl_tick),
    .tb_o   (tb_clk_o)
  );

  refchain_band_mux u_band (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .band_i  (band_i),
    .tb_en_i (tb_en_i),
    .tb_i    (tb_clk_o),
    .band_o  (band_o)
  );

  // R8: nothing is driven while the synchronized reset is low
  a_r8_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_n |-> (!ref_stb_o && !ctl_clk_o && !tb_clk_o && band_o == 3'b000));
endmodule

// File: tb/refchain_top_test.sv
module refchain_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int XTAL   = 7_200_000;
  localparam int TBHZ   = 4_000;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] ref_sel_i;
  logic [2:0] band_i;
  logic       tb_en_i;
  logic       ref_stb_o, ctl_clk_o, tb_clk_o;
  logic [2:0] band_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  refchain_top #(.XTAL_HZ(XTAL), .CTRL_HZ(400_000), .TB_HZ(TBHZ)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_sel_i(ref_sel_i), .band_i(band_i),
    .tb_en_i(tb_en_i), .ref_stb_o(ref_stb_o), .ctl_clk_o(ctl_clk_o),
    .tb_clk_o(tb_clk_o), .band_o(band_o)
  );

  function automatic int exp_period(input int code);
    int f;
    case (code)
      0: f = 100_000; 1: f = 50_000; 2: f = 25_000; 3: f = 5_000;
      4: f = 10_000;  5: f = 9_000;  6: f = 1_000;  default: f = 5_000;
    endcase
    return XTAL / f;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stb();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk_i);
      if (ref_stb_o) return;
    end
  endtask

  task automatic measure_stb(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk_i);
      n++;
      if (ref_stb_o) return;
    end
  endtask

  task automatic test_reset();
    rst_ni = 1'b0; ref_sel_i = 3'd0; band_i = 3'b111; tb_en_i = 1'b0;
    repeat (5) @(negedge clk_i);
    check("R8 ref_stb in reset", ref_stb_o, 0);
    check("R8 ctl_clk in reset", ctl_clk_o, 0);
    check("R8 tb_clk in reset",  tb_clk_o, 0);
    check("R8 band in reset",    band_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 band held one edge after release", band_o, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    check("R8 band live after sync release", band_o, 3'b111);
  endtask

  task automatic test_ref_code(input int code);
    int n;
    ref_sel_i = 3'(code);
    wait_stb();
    wait_stb();
    @(negedge clk_i);
    check($sformatf("R2 strobe width code %0d", code), ref_stb_o, 0);
    measure_stb(n);
    n++;
    check($sformatf("R1 period code %0d", code), n, exp_period(code));
  endtask

  task automatic test_ref_switch();
    int n;
    ref_sel_i = 3'd0;
    wait_stb();
    wait_stb();
    repeat (30) @(negedge clk_i);
    ref_sel_i = 3'd5;
    wait_stb();
    measure_stb(n);
    check("R3 first period after change uses new code", n, exp_period(5));
    ref_sel_i = 3'd0;
    @(negedge clk_i);
    measure_stb(n);
    check("R3 period in progress keeps old length", n + 1, exp_period(5));
  endtask

  task automatic test_ctl();
    int per = 0, hi = 0;
    for (int i = 0; i < 100 && !(ctl_clk_o == 1'b0); i++) @(negedge clk_i);
    for (int i = 0; i < 100 && !ctl_clk_o; i++) @(negedge clk_i);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      per++;
      if (ctl_clk_o) hi++;
      else if (hi > 0) begin
        for (int j = 0; j < 100 && !ctl_clk_o; j++) begin
          @(negedge clk_i);
          per++;
        end
        break;
      end
    end
    check("R4 ctl high phase", hi + 1, 9);
    check("R4 ctl period", per, 18);
  endtask

  task automatic test_tb();
    logic prev;
    int n;
    prev = tb_clk_o;
    for (int i = 0; i < 2000 && tb_clk_o == prev; i++) @(negedge clk_i);
    for (int k = 0; k < 2; k++) begin
      prev = tb_clk_o;
      n = 0;
      for (int i = 0; i < 2000 && tb_clk_o == prev; i++) begin
        @(negedge clk_i);
        n++;
      end
      check($sformatf("R5 tb half period %0d", k), n, XTAL / (2 * TBHZ));
    end
  endtask

  task automatic test_band();
    tb_en_i = 1'b0;
    for (int p = 0; p < 8; p += 3) begin
      band_i = 3'(p);
      @(negedge clk_i);
      check($sformatf("R6 band follows bits %0d", p), band_o, p);
    end
    band_i = 3'b101;
    @(negedge clk_i);
    check("R6 band 101", band_o, 5);
  endtask

  task automatic test_tb_band();
    logic prev;
    int bad = 0, toggles = 0;
    band_i = 3'b110;
    tb_en_i = 1'b1;
    @(negedge clk_i);
    prev = tb_clk_o;
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk_i);
      if (band_o[0] != prev) bad++;
      if (band_o[2:1] != 2'b11) bad++;
      if (tb_clk_o != prev) toggles++;
      prev = tb_clk_o;
    end
    check("R7 band0 tracks time base", bad, 0);
    check("R7 time base toggled while routed", toggles > 1, 1);
    tb_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    test_reset();
    for (int c = 0; c < 8; c++) test_ref_code(c);
    test_ref_switch();
    test_ctl();
    test_tb();
    test_band();
    test_tb_band();
    done = 1;
    finish_run();
  end
endmodule